// File: doc/BRIEF.md
# Index-Data Port Real-Time Clock

This block is a calendar clock that a host reaches through two byte-wide I/O locations. A write to the index location picks one internal register. A read of the data location then returns that register one cycle later, with a one-cycle valid strobe. The clock keeps seconds, minutes, hours, day of week, day of month, month and a year count. All of them are binary, and hours run in 24-hour form. They advance once per second, with the second derived from the system clock by a counter. The starting time comes from preset inputs, which the block copies while reset is held.

Three status and configuration registers give fixed or self-toggling values. One of them carries an update-in-progress bit that inverts on every read, so a polling loop always sees the bit change. A separate divider emits a one-cycle interrupt pulse at a programmable rate, 1024 per second by default. Some accesses are not supported: the alarm slots, the fourth control slot, unknown indices and any write to the data location. These raise a one-cycle error flag and change nothing.

Top module: `idx_rtc`

## Requirements
- R1: While `rstN` is low, every time register takes its preset input. The latched index becomes 0, the update-in-progress bit becomes 1, and `rdData`, `rdValid`, `errFlag` and `irqPulse` are 0. Presets must be in range.
- R2: A write with `ioAddr` = 0x70 latches `wrData` as the index. A read with `ioAddr` = 0x71 sets `rdValid` for exactly the next cycle. In that same cycle `rdData` holds the indexed register, and it keeps that value until the next data read. Valid indices: 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year, 10 to 12 control registers. Reads at other addresses have no effect.
- R3: A read of index 10 returns the update-in-progress bit in bit 7, ORed with 0x26. The bit then inverts. The first read after reset therefore gives 0xA6 and the second gives 0x26.
- R4: A read of index 11 always returns 0x46, and a read of index 12 always returns 0x00.
- R5: A second elapses every `CLKS_PER_SEC` clocks after reset. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day.
- R6: On a day carry, the day of month returns to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days when the year count is a multiple of 4 other than 0 and 200, and 28 days otherwise. Every other month has 31 days. Month 12 wraps to 1 and increments the year count modulo 256.
- R7: The day of week advances by one on each day carry and wraps from 6 to 0.
- R8: Index 9 reads as (year count − `YEAR_OFFSET`) modulo 256.
- R9: `irqPulse` is high for one cycle every `IRQ_DIV` clocks, where `IRQ_DIV` = `CLKS_PER_SEC`/`IRQ_RATE` (at least 1). The first pulse comes `IRQ_DIV` cycles after reset.
- R10: Each of the following raises `errFlag` for the next cycle and modifies no time register: a write at 0x71; a data read while the index is 1, 3, 5, 13 or above 13. Such a read still pulses `rdValid` and returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; loads presets |
| ioAddr | input | 8 | Byte address of the access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write byte |
| presetSec | input | 6 | Initial seconds |
| presetMin | input | 6 | Initial minutes |
| presetHour | input | 5 | Initial hours |
| presetWday | input | 3 | Initial day of week 0..6 |
| presetMday | input | 5 | Initial day of month |
| presetMon | input | 4 | Initial month 1..12 |
| presetYear | input | 8 | Initial internal year count |
| rdData | output | 8 | Registered read byte |
| rdValid | output | 1 | One-cycle strobe after a data read |
| errFlag | output | 1 | One-cycle unsupported-access flag |
| irqPulse | output | 1 | Periodic one-cycle interrupt pulse |

## Verification
The bench builds the block with `CLKS_PER_SEC` = 64 and `IRQ_RATE` = 16. A simulated second therefore takes 64 clocks, and the interrupt divider runs at 4. Presets placed a few seconds before midnight then reach every carry chain within a few hundred cycles. This covers a leap February, a common February, a 30-day month, the December-to-January wrap with the year count overflowing 255, and the weekday wrap. The short divider also lets the pulse spacing be compared on every clock against the reference model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int WDAY_W = 3;
  localparam int MDAY_W = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 8;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CTLA_BASE = 8'h26;
  localparam logic [BYTE_W-1:0] CTLB_VAL  = 8'h46;
  localparam logic [BYTE_W-1:0] CTLC_VAL  = 8'h00;

  typedef enum logic [3:0] {
    SEL_SEC, SEL_MIN, SEL_HOUR, SEL_WDAY, SEL_MDAY, SEL_MON, SEL_YEAR,
    SEL_CTLA, SEL_CTLB, SEL_CTLC, SEL_BAD
  } rtcSel_e;

  typedef struct packed {
    logic    secTick;
    logic    dataRd;
    rtcSel_e sel;
  } rtcStrobe_t;

  // Year count is years past 1900: leap when divisible by 4, except 1900 and 2100.
  function automatic logic [MDAY_W-1:0] daysInMonth(input logic [MON_W-1:0] mon,
                                                    input logic [YEAR_W-1:0] yr);
    logic leap;
    leap = (yr[1:0] == 2'b00) && (yr != 8'd0) && (yr != 8'd200);
    case (mon)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int               CLKS_PER_SEC = 100_000_000,
  parameter int               IRQ_DIV      = 97656,
  parameter logic [7:0]       INDEX_ADDR   = 8'h70,
  parameter logic [7:0]       DATA_ADDR    = 8'h71
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] ioAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output rtcStrobe_t        strobe,
  output logic              errFlag,
  output logic              irqPulse
);
  localparam int SEC_CNT_W = $clog2(CLKS_PER_SEC + 1);
  localparam logic [SEC_CNT_W-1:0] SEC_LAST = SEC_CNT_W'(CLKS_PER_SEC - 1);

  logic [BYTE_W-1:0]    indexReg;
  logic [SEC_CNT_W-1:0] secCnt;
  rtcSel_e              selDec;
  logic                 dataWr;

  always_comb begin
    case (indexReg)
      8'd0:    selDec = SEL_SEC;
      8'd2:    selDec = SEL_MIN;
      8'd4:    selDec = SEL_HOUR;
      8'd6:    selDec = SEL_WDAY;
      8'd7:    selDec = SEL_MDAY;
      8'd8:    selDec = SEL_MON;
      8'd9:    selDec = SEL_YEAR;
      8'd10:   selDec = SEL_CTLA;
      8'd11:   selDec = SEL_CTLB;
      8'd12:   selDec = SEL_CTLC;
      default: selDec = SEL_BAD;
    endcase
  end

  assign dataWr         = wrEn && (ioAddr == DATA_ADDR);
  assign strobe.dataRd  = rdEn && (ioAddr == DATA_ADDR);
  assign strobe.secTick = (secCnt == SEC_LAST);
  assign strobe.sel     = selDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      secCnt   <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (wrEn && (ioAddr == INDEX_ADDR)) indexReg <= wrData;
      secCnt  <= strobe.secTick ? '0 : secCnt + 1'b1;
      errFlag <= dataWr || (strobe.dataRd && (selDec == SEL_BAD));
    end
  end

  generate
    if (IRQ_DIV > 1) begin : g_irqDiv
      localparam int IRQ_CNT_W = $clog2(IRQ_DIV + 1);
      localparam logic [IRQ_CNT_W-1:0] IRQ_LAST = IRQ_CNT_W'(IRQ_DIV - 1);
      logic [IRQ_CNT_W-1:0] irqCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          irqCnt   <= '0;
          irqPulse <= 1'b0;
        end else begin
          irqPulse <= (irqCnt == IRQ_LAST);
          irqCnt   <= (irqCnt == IRQ_LAST) ? '0 : irqCnt + 1'b1;
        end
      end
      // R9: a pulse never lasts two cycles when the divider exceeds one
      a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
        irqPulse |=> !irqPulse);
    end else begin : g_irqEvery
      always_ff @(posedge clk) irqPulse <= rstN;
    end
  endgenerate

  // R10: a data-port write is always flagged on the next cycle
  a_r10_write_flag: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> errFlag);
  // R10: a read of an unsupported slot is always flagged
  a_r10_bad_read_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && strobe.sel == SEL_BAD) |=> errFlag);
  // R2: the index only changes after an index-port write
  a_r2_index_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && ioAddr == INDEX_ADDR) |=> $stable(indexReg));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int YEAR_OFFSET = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic [SEC_W-1:0]  presetSec,
  input  logic [MIN_W-1:0]  presetMin,
  input  logic [HOUR_W-1:0] presetHour,
  input  logic [WDAY_W-1:0] presetWday,
  input  logic [MDAY_W-1:0] presetMday,
  input  logic [MON_W-1:0]  presetMon,
  input  logic [YEAR_W-1:0] presetYear,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid
);
  localparam logic [YEAR_W-1:0] YEAR_OFF = YEAR_W'(YEAR_OFFSET);

  logic [SEC_W-1:0]  secReg;
  logic [MIN_W-1:0]  minReg;
  logic [HOUR_W-1:0] hourReg;
  logic [WDAY_W-1:0] wdayReg;
  logic [MDAY_W-1:0] mdayReg;
  logic [MON_W-1:0]  monReg;
  logic [YEAR_W-1:0] yearReg;
  logic              uipFlag;
  logic [BYTE_W-1:0] muxVal;
  logic incMin, incHour, incDay, incMon, incYear;

  assign incMin  = strobe.secTick && (secReg == 6'd59);
  assign incHour = incMin  && (minReg  == 6'd59);
  assign incDay  = incHour && (hourReg == 5'd23);
  assign incMon  = incDay  && (mdayReg == daysInMonth(monReg, yearReg));
  assign incYear = incMon  && (monReg  == 4'd12);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg  <= presetSec;
      minReg  <= presetMin;
      hourReg <= presetHour;
      wdayReg <= presetWday;
      mdayReg <= presetMday;
      monReg  <= presetMon;
      yearReg <= presetYear;
    end else begin
      if (strobe.secTick) secReg  <= incMin  ? '0 : secReg + 1'b1;
      if (incMin)         minReg  <= incHour ? '0 : minReg + 1'b1;
      if (incHour)        hourReg <= incDay  ? '0 : hourReg + 1'b1;
      if (incDay) begin
        wdayReg <= (wdayReg == 3'd6) ? '0 : wdayReg + 1'b1;
        mdayReg <= incMon ? 5'd1 : mdayReg + 1'b1;
      end
      if (incMon)         monReg  <= incYear ? 4'd1 : monReg + 1'b1;
      if (incYear)        yearReg <= yearReg + 1'b1;
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_SEC:  muxVal = BYTE_W'(secReg);
      SEL_MIN:  muxVal = BYTE_W'(minReg);
      SEL_HOUR: muxVal = BYTE_W'(hourReg);
      SEL_WDAY: muxVal = BYTE_W'(wdayReg);
      SEL_MDAY: muxVal = BYTE_W'(mdayReg);
      SEL_MON:  muxVal = BYTE_W'(monReg);
      SEL_YEAR: muxVal = yearReg - YEAR_OFF;
      SEL_CTLA: muxVal = {uipFlag, 7'b0} | CTLA_BASE;
      SEL_CTLB: muxVal = CTLB_VAL;
      SEL_CTLC: muxVal = CTLC_VAL;
      default:  muxVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uipFlag <= 1'b1;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.dataRd;
      if (strobe.dataRd) rdData <= muxVal;
      if (strobe.dataRd && strobe.sel == SEL_CTLA) uipFlag <= ~uipFlag;
    end
  end

  // R3: each control-A read inverts the in-progress bit
  a_r3_uip_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && strobe.sel == SEL_CTLA) |=> (uipFlag != $past(uipFlag)));
  // R2: a valid strobe follows every data read
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataRd |=> rdValid);
  // R5: clock fields stay in range
  a_r5_time_range: assert property (@(posedge clk) disable iff (!rstN)
    (secReg <= 6'd59) && (minReg <= 6'd59) && (hourReg <= 5'd23));
  // R6: date fields stay in range
  a_r6_date_range: assert property (@(posedge clk) disable iff (!rstN)
    (monReg >= 4'd1) && (monReg <= 4'd12) && (mdayReg >= 5'd1)
    && (mdayReg <= daysInMonth(monReg, yearReg)));
  // R7: weekday never passes 6
  a_r7_wday_range: assert property (@(posedge clk) disable iff (!rstN)
    wdayReg <= 3'd6);
  // R5: seconds move only on a tick
  a_r5_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.secTick |=> $stable(secReg));
endmodule

// File: rtl/idx_rtc.sv
module idx_rtc
  import rtc_pkg::*;
#(
  parameter int         CLKS_PER_SEC = 100_000_000,
  parameter int         IRQ_RATE     = 1024,
  parameter int         YEAR_OFFSET  = 52,
  parameter logic [7:0] INDEX_ADDR   = 8'h70,
  parameter logic [7:0] DATA_ADDR    = 8'h71
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  input  logic [5:0] presetSec,
  input  logic [5:0] presetMin,
  input  logic [4:0] presetHour,
  input  logic [2:0] presetWday,
  input  logic [4:0] presetMday,
  input  logic [3:0] presetMon,
  input  logic [7:0] presetYear,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       errFlag,
  output logic       irqPulse
);
  localparam int IRQ_DIV = (CLKS_PER_SEC / IRQ_RATE > 0) ? CLKS_PER_SEC / IRQ_RATE : 1;

  rtcStrobe_t strobe;

  rtc_ctrl #(
    .CLKS_PER_SEC(CLKS_PER_SEC), .IRQ_DIV(IRQ_DIV),
    .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strobe(strobe), .errFlag(errFlag), .irqPulse(irqPulse)
  );

  rtc_datapath #(.YEAR_OFFSET(YEAR_OFFSET)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .presetSec(presetSec), .presetMin(presetMin), .presetHour(presetHour),
    .presetWday(presetWday), .presetMday(presetMday), .presetMon(presetMon),
    .presetYear(presetYear), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/test_idx_rtc.sv
module test_idx_rtc;
  localparam int CPS  = 64;
  localparam int RATE = 16;
  localparam int IDIV = CPS / RATE;
  localparam int YOFF = 52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = 8'h00;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [5:0] presetSec = 0, presetMin = 0;
  logic [4:0] presetHour = 0, presetMday = 1;
  logic [2:0] presetWday = 0;
  logic [3:0] presetMon = 1;
  logic [7:0] presetYear = 0;
  logic [7:0] rdData;
  logic rdValid, errFlag, irqPulse;

  idx_rtc #(.CLKS_PER_SEC(CPS), .IRQ_RATE(RATE), .YEAR_OFFSET(YOFF)) i_idx_rtc (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .presetSec(presetSec), .presetMin(presetMin), .presetHour(presetHour),
    .presetWday(presetWday), .presetMday(presetMday), .presetMon(presetMon),
    .presetYear(presetYear), .rdData(rdData), .rdValid(rdValid),
    .errFlag(errFlag), .irqPulse(irqPulse)
  );

  always #2 clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit cmpOn = 0;
  int mSec, mMin, mHour, mWday, mMday, mMon, mYear, mIdx, mUip, secCnt, irqCnt;
  int expRd = 0, expVal = 0, expErr = 0, expIrq = 0;
  string expTag = "R1";

  function automatic int dim(int mon, int yr);
    int a = 1900 + yr;
    bit leap = ((a % 4 == 0) && (a % 100 != 0)) || (a % 400 == 0);
    if (mon == 2) return leap ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic advanceSecond();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0; mWday = (mWday + 1) % 7; mMday++;
          if (mMday > dim(mMon, mYear)) begin
            mMday = 1; mMon++;
            if (mMon == 13) begin mMon = 1; mYear = (mYear + 1) % 256; end
          end
        end
      end
    end
  endtask

  // Behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    cmpOn = 1;
    if (!rstN) begin
      mSec = presetSec; mMin = presetMin; mHour = presetHour; mWday = presetWday;
      mMday = presetMday; mMon = presetMon; mYear = presetYear;
      mIdx = 0; mUip = 1; secCnt = 0; irqCnt = 0;
      expRd = 0; expVal = 0; expErr = 0; expIrq = 0; expTag = "R1";
    end else begin
      expVal = 0; expErr = 0;
      expIrq = (irqCnt == IDIV - 1) ? 1 : 0;
      irqCnt = expIrq ? 0 : irqCnt + 1;
      if (wrEn && ioAddr == 8'h70) mIdx = wrData;
      if (wrEn && ioAddr == 8'h71) expErr = 1;
      if (rdEn && ioAddr == 8'h71) begin
        expVal = 1;
        case (mIdx)
          0:  begin expRd = mSec;  expTag = "R5"; end
          2:  begin expRd = mMin;  expTag = "R5"; end
          4:  begin expRd = mHour; expTag = "R5"; end
          6:  begin expRd = mWday; expTag = "R7"; end
          7:  begin expRd = mMday; expTag = "R6"; end
          8:  begin expRd = mMon;  expTag = "R6"; end
          9:  begin expRd = (mYear + 256 - YOFF) % 256; expTag = "R8"; end
          10: begin expRd = (mUip ? 8'h80 : 8'h00) | 8'h26; mUip = 1 - mUip; expTag = "R3"; end
          11: begin expRd = 8'h46; expTag = "R4"; end
          12: begin expRd = 8'h00; expTag = "R4"; end
          default: begin expRd = 0; expErr = 1; expTag = "R10"; end
        endcase
      end
      if (secCnt == CPS - 1) begin secCnt = 0; advanceSecond(); end
      else secCnt++;
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    cmp(expTag, "rdData", int'(rdData), expRd);
    cmp("R2", "rdValid", int'(rdValid), expVal);
    cmp("R10", "errFlag", int'(errFlag), expErr);
    cmp("R9", "irqPulse", int'(irqPulse), expIrq);
  end

  task automatic selIdx(input logic [7:0] i);
    @(negedge clk); wrEn = 1; ioAddr = 8'h70; wrData = i;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readIdx(input logic [7:0] i);
    selIdx(i);
    rdEn = 1; ioAddr = 8'h71;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic readAll();
    readIdx(0); readIdx(2); readIdx(4); readIdx(6); readIdx(7);
    readIdx(8); readIdx(9); readIdx(10); readIdx(10); readIdx(11); readIdx(12);
    // R10: unsupported slots and a data-port write
    readIdx(13); readIdx(1); readIdx(3); readIdx(5); readIdx(40);
    @(negedge clk); wrEn = 1; ioAddr = 8'h71; wrData = 8'hFF;
    @(negedge clk); wrEn = 0;
    // R2: reads at the index port change nothing
    rdEn = 1; ioAddr = 8'h70;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic scenario(int s, int mi, int h, int wd, int md, int mo, int y, int loops);
    @(negedge clk);
    rstN = 0;
    presetSec = 6'(s); presetMin = 6'(mi); presetHour = 5'(h); presetWday = 3'(wd);
    presetMday = 5'(md); presetMon = 4'(mo); presetYear = 8'(y);
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int k = 0; k < loops; k++) begin
      readAll();
      repeat (40) @(negedge clk);
    end
  endtask

  initial begin
    scenario(50, 59, 23, 6, 28, 2, 104, 20);   // R6 leap February, R7 weekday wrap
    scenario(55, 59, 23, 2, 28, 2, 105, 12);   // R6 common February
    scenario(55, 59, 23, 3, 30, 4, 110, 12);   // R6 thirty-day month
    scenario(55, 59, 23, 4, 31, 12, 255, 12);  // R6 year wrap, R8 offset
    scenario(58, 59, 23, 0, 28, 2, 200, 10);   // R6 no leap at count 200
    scenario(10, 34, 12, 1, 15, 7, 106, 8);    // R5 midday run
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule